// File: doc/BRIEF.md
# Full-Duplex Serial Port with Hardware Handshake

This block is a full-duplex asynchronous serial port with handshake lines. It sends and receives frames of one start bit, eight data bits sent least significant bit first, and one stop bit, with no parity. Both directions share one baud tick from a programmable divider. Each bit lasts sixteen ticks. The transmitter takes bytes from a one-entry holding register. The receiver places each good byte into a one-entry result register, where the host collects it with a read strobe.

Two handshake lines pace the traffic. The clear-to-send input is active low and is synchronized inside the block. When its enable is set, it gates the start of every new data frame. It never cuts short a frame that is already on the line. The request-to-send output is active low and tells the far end whether the result register still has room. Any change on the clear-to-send line sets a sticky flag, which can drive an interrupt output. A break request sends a long low level and is not gated by clear-to-send.

Top module: `uart_handshake`

## Requirements
- R1: A data frame on `txd` is one low start bit, then eight data bits with bit 0 first, then one high stop bit. Each bit lasts 16 ticks, and one tick is `baud_div`+1 clock cycles. `txd` is high whenever no frame is being sent.
- R2: The transmit holding register has one entry. `tx_empty` goes low on the clock after `tx_wr`. A `tx_wr` while the entry is still full is discarded, and that byte is never sent.
- R3: While `cts_en` is 1, a frame starts only at a frame boundary where the synchronized `cts_n` is 0. While `cts_n` stays 1, the waiting byte stays held and `txd` stays high.
- R4: If `cts_n` rises while a frame is being sent, that frame still completes through its stop bit with the correct data. The next waiting byte is then held.
- R5: While `cts_en` is 0, `cts_n` has no effect on transmission.
- R6: A pulse on `brk_req` sends a break: `txd` is held low for ten bit times, then high for one stop bit. A break is sent even while `cts_n` is 1 with `cts_en` set. A pending break goes out before a waiting data byte.
- R7: The receiver samples each bit near its middle. A frame with a high stop bit sets `rx_full` and shows the byte on `rx_data`. A frame whose stop bit is low is discarded.
- R8: While `rx_full` is 1, a newly received byte is dropped, and `rx_data` keeps its value.
- R9: With `rts_en` at 1, `rts_n` equals `rx_full`. With `rts_en` at 0, `rts_n` is held at 0. A pulse on `rx_rd` clears `rx_full`, so `rts_n` is 0 on the next clock.
- R10: `cts_n` passes through two synchronizer flops. While `cts_en` is 1, every rising or falling change of `cts_n` sets `cts_chg` two clocks after the clock edge that first samples the new level. `cts_chg` stays set until a pulse on `cts_chg_clr`. A new change in the same cycle as the clear wins. While `cts_en` is 0, changes do not set the flag.
- R11: `cts_irq` is 1 exactly while both `cts_chg` and `cts_irq_en` are 1.
- R12: After reset: `txd` is 1, `rts_n` is 0, `tx_empty` is 1, `tx_busy` is 0, `rx_full` is 0, `cts_chg` is 0 and `cts_irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_div | input | 16 | Tick period minus one, in clock cycles |
| rts_en | input | 1 | Enables request-to-send pacing |
| cts_en | input | 1 | Enables clear-to-send gating and change detection |
| cts_irq_en | input | 1 | Enables the change interrupt |
| tx_wr | input | 1 | Writes `tx_data` into the holding register |
| tx_data | input | 8 | Byte to send |
| brk_req | input | 1 | Requests a break frame (pulse) |
| tx_empty | output | 1 | Holding register is free |
| tx_busy | output | 1 | A frame or break is on the line |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input |
| rx_data | output | 8 | Last accepted byte |
| rx_full | output | 1 | Result register holds an unread byte |
| rx_rd | input | 1 | Read strobe; clears `rx_full` |
| cts_n | input | 1 | Clear-to-send, active low |
| rts_n | output | 1 | Request-to-send, active low |
| cts_chg | output | 1 | Sticky clear-to-send change flag |
| cts_chg_clr | input | 1 | Clears `cts_chg` (pulse) |
| cts_irq | output | 1 | Change interrupt |

## Verification
Two events can land on the same clock edge: a clear pulse on the change flag and a newly detected `cts_n` edge. To provoke this, the bench toggles `cts_n` and raises `cts_chg_clr` exactly on the edge where the synchronized change reaches the detector. The result passes only if the flag remains set afterwards. A behavioural model in the bench keeps a short history of sampled `cts_n` levels and recomputes the expected flag and interrupt at every clock, so the collision is judged both by the model and by an explicit check.

// File: rtl/uhs_pkg.sv
package uhs_pkg;
  localparam int OVS = 16;

  typedef enum logic [2:0] {
    TX_IDLE, TX_START, TX_DATA, TX_STOP, TX_BREAK
  } tx_st_e;

  typedef enum logic [1:0] {
    RX_IDLE, RX_START, RX_DATA, RX_STOP
  } rx_st_e;
endpackage

// File: rtl/uhs_baud.sv
module uhs_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = (cnt_q >= div);
    cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/uhs_cts.sv
module uhs_cts (
  input  logic clk,
  input  logic rst_n,
  input  logic cts_n,
  input  logic cts_en,
  input  logic clr,
  input  logic irq_en,
  output logic cts_s,
  output logic flag,
  output logic irq
);
  logic s1_q, s2_q, s3_q, flag_q, flag_d, edge_seen;

  always_comb begin
    edge_seen = cts_en && (s2_q != s3_q);
    flag_d    = (flag_q && !clr) || edge_seen;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b1; s2_q <= 1'b1; s3_q <= 1'b1; flag_q <= 1'b0;
    end else begin
      s1_q <= cts_n; s2_q <= s1_q; s3_q <= s2_q; flag_q <= flag_d;
    end
  end

  assign cts_s = s2_q;
  assign flag  = flag_q;
  assign irq   = flag_q && irq_en;

  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr) |=> flag_q);
  p_set_needs_en_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(cts_en));
endmodule

// File: rtl/uhs_tx.sv
module uhs_tx
  import uhs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              brk_req,
  input  logic              cts_en,
  input  logic              cts_s,
  output logic              line,
  output logic              empty,
  output logic              busy
);
  localparam int SUB_W = $clog2(OVS);
  localparam int BC_W  = $clog2(DATA_W + 2);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVS - 1);
  localparam logic [BC_W-1:0]  BC_DLAST = BC_W'(DATA_W - 1);
  localparam logic [BC_W-1:0]  BC_BLAST = BC_W'(DATA_W + 1);

  tx_st_e            st_q, st_d;
  logic [SUB_W-1:0]  sub_q, sub_d;
  logic [BC_W-1:0]   bc_q, bc_d;
  logic [DATA_W-1:0] sh_q, sh_d, hold_q, hold_d;
  logic              hvld_q, hvld_d, brk_q, brk_d, line_q, line_d;
  logic              bit_end;

  always_comb begin
    st_d = st_q; sub_d = sub_q; bc_d = bc_q; sh_d = sh_q;
    hold_d = hold_q; hvld_d = hvld_q; line_d = line_q;
    brk_d = brk_q || brk_req;
    bit_end = (sub_q == SUB_LAST);
    if (wr && !hvld_q) begin
      hvld_d = 1'b1;
      hold_d = wdata;
    end
    if (tick) begin
      if (st_q != TX_IDLE) sub_d = bit_end ? '0 : sub_q + 1'b1;
      case (st_q)
        TX_IDLE: begin
          if (brk_q) begin
            st_d = TX_BREAK; sub_d = '0; bc_d = '0; line_d = 1'b0;
            brk_d = brk_req;
          end else if (hvld_q && (!cts_en || !cts_s)) begin
            st_d = TX_START; sub_d = '0; sh_d = hold_q; hvld_d = 1'b0;
            line_d = 1'b0;
          end
        end
        TX_START: begin
          if (bit_end) begin
            st_d = TX_DATA; bc_d = '0; line_d = sh_q[0];
          end
        end
        TX_DATA: begin
          if (bit_end) begin
            if (bc_q == BC_DLAST) begin
              st_d = TX_STOP; line_d = 1'b1;
            end else begin
              sh_d = sh_q >> 1; line_d = sh_q[1]; bc_d = bc_q + 1'b1;
            end
          end
        end
        TX_BREAK: begin
          if (bit_end) begin
            if (bc_q == BC_BLAST) begin
              st_d = TX_STOP; line_d = 1'b1;
            end else begin
              bc_d = bc_q + 1'b1;
            end
          end
        end
        TX_STOP: begin
          if (bit_end) st_d = TX_IDLE;
        end
        default: st_d = TX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= TX_IDLE; sub_q <= '0; bc_q <= '0; sh_q <= '0;
      hold_q <= '0; hvld_q <= 1'b0; brk_q <= 1'b0; line_q <= 1'b1;
    end else begin
      st_q <= st_d; sub_q <= sub_d; bc_q <= bc_d; sh_q <= sh_d;
      hold_q <= hold_d; hvld_q <= hvld_d; brk_q <= brk_d; line_q <= line_d;
    end
  end

  assign line  = line_q;
  assign empty = !hvld_q;
  assign busy  = (st_q != TX_IDLE);

  p_cts_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == TX_START && $past(st_q) == TX_IDLE) |-> (!$past(cts_en) || !$past(cts_s)));
  p_no_abort_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == TX_IDLE && $past(st_q) != TX_IDLE) |-> ($past(st_q) == TX_STOP));
  p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == TX_IDLE) |-> line_q);
endmodule

// File: rtl/uhs_rx.sv
module uhs_rx
  import uhs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              line,
  input  logic              rd,
  output logic [DATA_W-1:0] data,
  output logic              full
);
  localparam int SUB_W = $clog2(OVS);
  localparam int BC_W  = $clog2(DATA_W);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVS - 1);
  localparam logic [SUB_W-1:0] SUB_MID  = SUB_W'(OVS / 2 - 1);
  localparam logic [BC_W-1:0]  BC_LAST  = BC_W'(DATA_W - 1);

  rx_st_e            st_q, st_d;
  logic [SUB_W-1:0]  sub_q, sub_d;
  logic [BC_W-1:0]   bc_q, bc_d;
  logic [DATA_W-1:0] sh_q, sh_d, data_q, data_d;
  logic              m1_q, ls_q, full_q, full_d, done, wr_en;

  always_comb begin
    st_d = st_q; sub_d = sub_q; bc_d = bc_q; sh_d = sh_q;
    done = 1'b0;
    if (tick) begin
      case (st_q)
        RX_IDLE: if (!ls_q) begin st_d = RX_START; sub_d = '0; end
        RX_START: begin
          if (sub_q == SUB_MID) begin
            sub_d = '0; bc_d = '0;
            st_d  = ls_q ? RX_IDLE : RX_DATA;
          end else sub_d = sub_q + 1'b1;
        end
        RX_DATA: begin
          if (sub_q == SUB_LAST) begin
            sub_d = '0;
            sh_d  = {ls_q, sh_q[DATA_W-1:1]};
            if (bc_q == BC_LAST) st_d = RX_STOP;
            else bc_d = bc_q + 1'b1;
          end else sub_d = sub_q + 1'b1;
        end
        RX_STOP: begin
          if (sub_q == SUB_LAST) begin
            st_d = RX_IDLE; sub_d = '0; done = ls_q;
          end else sub_d = sub_q + 1'b1;
        end
        default: st_d = RX_IDLE;
      endcase
    end
    wr_en  = done && !full_q;
    full_d = full_q;
    data_d = data_q;
    if (rd) full_d = 1'b0;
    if (wr_en) begin
      full_d = 1'b1;
      data_d = sh_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= RX_IDLE; sub_q <= '0; bc_q <= '0; sh_q <= '0;
      data_q <= '0; full_q <= 1'b0; m1_q <= 1'b1; ls_q <= 1'b1;
    end else begin
      st_q <= st_d; sub_q <= sub_d; bc_q <= bc_d; sh_q <= sh_d;
      data_q <= data_d; full_q <= full_d; m1_q <= line; ls_q <= m1_q;
    end
  end

  assign data = data_q;
  assign full = full_q;

  p_rd_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !wr_en) |=> !full_q);
  p_hold_when_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && !rd) |=> (full_q && $stable(data_q)));
endmodule

// File: rtl/uart_handshake.sv
module uart_handshake #(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  baud_div,
  input  logic              rts_en,
  input  logic              cts_en,
  input  logic              cts_irq_en,
  input  logic              tx_wr,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              brk_req,
  output logic              tx_empty,
  output logic              tx_busy,
  output logic              txd,
  input  logic              rxd,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_full,
  input  logic              rx_rd,
  input  logic              cts_n,
  output logic              rts_n,
  output logic              cts_chg,
  input  logic              cts_chg_clr,
  output logic              cts_irq
);
  logic rs1_q, rs2_q, tick, cts_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0; rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1; rs2_q <= rs1_q;
    end
  end

  uhs_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(rs2_q), .div(baud_div), .tick(tick));

  uhs_cts u_cts (
    .clk(clk), .rst_n(rs2_q), .cts_n(cts_n), .cts_en(cts_en),
    .clr(cts_chg_clr), .irq_en(cts_irq_en), .cts_s(cts_s),
    .flag(cts_chg), .irq(cts_irq));

  uhs_tx #(.DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst_n(rs2_q), .tick(tick), .wr(tx_wr), .wdata(tx_data),
    .brk_req(brk_req), .cts_en(cts_en), .cts_s(cts_s), .line(txd),
    .empty(tx_empty), .busy(tx_busy));

  uhs_rx #(.DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst_n(rs2_q), .tick(tick), .line(rxd), .rd(rx_rd),
    .data(rx_data), .full(rx_full));

  assign rts_n = rts_en && rx_full;

  p_irq_needs_flag_r11: assert property (@(posedge clk) disable iff (!rs2_q)
    cts_irq |-> cts_chg);
endmodule

// File: tb/uart_handshake_tb_top.sv
module uart_handshake_tb_top;
  localparam int BP = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] baud_div = 16'd1;
  logic rts_en = 0, cts_en = 0, cts_irq_en = 0, tx_wr = 0, brk_req = 0;
  logic [7:0] tx_data = '0;
  logic rxd = 1, rx_rd = 0, cts_n = 1, cts_chg_clr = 0;
  logic tx_empty, tx_busy, txd, rx_full, rts_n, cts_chg, cts_irq;
  logic [7:0] rx_data;

  int checks = 0, fails = 0;
  int got_q[$];
  int brk_low;
  logic m_flag = 0, h0 = 1, h1 = 1, h2 = 1;

  always #10 clk = ~clk;

  uart_handshake dut_i (
    .clk(clk), .rst_n(rst_n), .baud_div(baud_div), .rts_en(rts_en),
    .cts_en(cts_en), .cts_irq_en(cts_irq_en), .tx_wr(tx_wr), .tx_data(tx_data),
    .brk_req(brk_req), .tx_empty(tx_empty), .tx_busy(tx_busy), .txd(txd),
    .rxd(rxd), .rx_data(rx_data), .rx_full(rx_full), .rx_rd(rx_rd),
    .cts_n(cts_n), .rts_n(rts_n), .cts_chg(cts_chg), .cts_chg_clr(cts_chg_clr),
    .cts_irq(cts_irq));

  task automatic chk(input string rq, input logic ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // Reference model of the change flag: history of sampled cts_n levels.
  always @(posedge clk) begin
    if (!rst_n) begin
      m_flag = 0; h0 = 1; h1 = 1; h2 = 1;
    end else begin
      m_flag = (m_flag && !cts_chg_clr) || (cts_en && (h1 != h2));
      h2 = h1; h1 = h0; h0 = cts_n;
    end
  end

  // Compared on every clock, away from the active edge (R10, R11).
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R10 flag model", cts_chg === m_flag, int'(cts_chg), int'(m_flag));
      chk("R11 irq model", cts_irq === (m_flag && cts_irq_en), int'(cts_irq),
          int'(m_flag && cts_irq_en));
    end
  end

  // Serial monitor on txd: 256 marks a break.
  initial begin
    logic [7:0] b;
    logic stp;
    int lo;
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      while (txd !== 1'b0) @(negedge clk);
      repeat (BP / 2) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
        repeat (BP) @(negedge clk);
        b[i] = txd;
      end
      repeat (BP) @(negedge clk);
      stp = txd;
      if (stp) got_q.push_back(int'(b));
      else begin
        lo = BP / 2 + 9 * BP;
        while (txd === 1'b0) begin @(negedge clk); lo++; end
        brk_low = lo;
        got_q.push_back(256);
      end
    end
  end

  task automatic wbits(input int n);
    repeat (n * BP) @(negedge clk);
  endtask

  task automatic write_tx(input logic [7:0] d);
    tx_data = d; tx_wr = 1;
    @(negedge clk);
    tx_wr = 0;
  endtask

  task automatic send_rx(input logic [7:0] d, input logic stp);
    rxd = 0; wbits(1);
    for (int i = 0; i < 8; i++) begin rxd = d[i]; wbits(1); end
    rxd = stp; wbits(1);
    rxd = 1; wbits(2);
  endtask

  task automatic expect_got(input string rq, input int exp);
    if (got_q.size() == 0) chk(rq, 1'b0, -1, exp);
    else begin
      int g = got_q.pop_front();
      chk(rq, g == exp, g, exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk("watchdog", 1'b0, 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R12 reset state
    chk("R12 txd", txd === 1'b1, int'(txd), 1);
    chk("R12 rts_n", rts_n === 1'b0, int'(rts_n), 0);
    chk("R12 tx_empty", tx_empty === 1'b1, int'(tx_empty), 1);
    chk("R12 tx_busy", tx_busy === 1'b0, int'(tx_busy), 0);
    chk("R12 rx_full", rx_full === 1'b0, int'(rx_full), 0);
    chk("R12 cts_chg", cts_chg === 1'b0, int'(cts_chg), 0);

    // R1, R5: gating off, cts_n high and toggling is ignored
    write_tx(8'hA5);
    chk("R2 tx_empty low after write", tx_empty === 1'b0, int'(tx_empty), 0);
    cts_n = 0; repeat (5) @(negedge clk); cts_n = 1;
    while (!tx_empty) @(negedge clk);
    write_tx(8'h3C);
    wbits(24);
    expect_got("R1 frame A5", 8'hA5);
    expect_got("R5 frame 3C with cts_n high", 8'h3C);
    chk("R1 txd idle high", txd === 1'b1, int'(txd), 1);

    // R4, R3, R2: gate on, deassert mid-frame
    cts_en = 1; cts_n = 0; wbits(1);
    write_tx(8'h5A);
    while (!tx_busy) @(negedge clk);
    write_tx(8'h77);
    wbits(3);
    cts_n = 1;
    write_tx(8'h99);               // entry full: dropped (R2)
    wbits(24);
    expect_got("R4 frame 5A completes", 8'h5A);
    chk("R3 no frame while cts_n high", got_q.size() == 0, got_q.size(), 0);
    chk("R3 byte held", tx_empty === 1'b0, int'(tx_empty), 0);
    chk("R3 txd high while held", txd === 1'b1, int'(txd), 1);
    cts_n = 0;
    wbits(24);
    expect_got("R3 held byte 77 sent", 8'h77);
    chk("R2 dropped byte not sent", got_q.size() == 0, got_q.size(), 0);

    // R6: break bypasses the gate and precedes a waiting byte
    cts_n = 1; wbits(1);
    write_tx(8'h42);
    brk_req = 1; @(negedge clk); brk_req = 0;
    wbits(16);
    expect_got("R6 break sent with cts_n high", 256);
    chk("R6 break length", brk_low >= 9 * BP + BP / 2, brk_low, 10 * BP);
    chk("R6 data still held", tx_empty === 1'b0, int'(tx_empty), 0);
    cts_n = 0;
    wbits(14);
    expect_got("R6 byte after break", 8'h42);

    // R7, R8, R9: receive path
    rts_en = 1;
    send_rx(8'h96, 1'b1);
    chk("R7 rx_full", rx_full === 1'b1, int'(rx_full), 1);
    chk("R7 rx_data", rx_data === 8'h96, int'(rx_data), 8'h96);
    chk("R9 rts_n high when full", rts_n === 1'b1, int'(rts_n), 1);
    send_rx(8'h0F, 1'b1);
    chk("R8 byte dropped when full", rx_data === 8'h96, int'(rx_data), 8'h96);
    rx_rd = 1; @(negedge clk); rx_rd = 0;
    chk("R9 rx_full cleared", rx_full === 1'b0, int'(rx_full), 0);
    chk("R9 rts_n low after read", rts_n === 1'b0, int'(rts_n), 0);
    send_rx(8'h55, 1'b0);
    chk("R7 bad stop discarded", rx_full === 1'b0, int'(rx_full), 0);
    rts_en = 0;
    send_rx(8'hC3, 1'b1);
    chk("R7 rx_data C3", rx_data === 8'hC3, int'(rx_data), 8'hC3);
    chk("R9 rts_n low when disabled", rts_n === 1'b0, int'(rts_n), 0);
    rx_rd = 1; @(negedge clk); rx_rd = 0;

    // R10, R11: change flag and interrupt
    cts_chg_clr = 1; @(negedge clk); cts_chg_clr = 0;
    chk("R10 flag cleared", cts_chg === 1'b0, int'(cts_chg), 0);
    cts_irq_en = 1;
    cts_n = 1; repeat (4) @(negedge clk);
    chk("R10 rising sets flag", cts_chg === 1'b1, int'(cts_chg), 1);
    chk("R11 irq raised", cts_irq === 1'b1, int'(cts_irq), 1);
    cts_irq_en = 0; @(negedge clk);
    chk("R11 irq masked", cts_irq === 1'b0, int'(cts_irq), 0);
    cts_chg_clr = 1; @(negedge clk); cts_chg_clr = 0;
    cts_n = 0;                    // sampled at next edge k0
    @(negedge clk); @(negedge clk);
    cts_chg_clr = 1;              // lands on edge k0+2 with the set
    @(negedge clk); cts_chg_clr = 0;
    chk("R10 set wins over clear", cts_chg === 1'b1, int'(cts_chg), 1);
    cts_chg_clr = 1; @(negedge clk); cts_chg_clr = 0;
    cts_en = 0; cts_n = 1; repeat (5) @(negedge clk);
    chk("R10 no set when disabled", cts_chg === 1'b0, int'(cts_chg), 0);

    finish_run();
  end
endmodule